// File: doc/BRIEF.md
# Cross-Side Flag Update Tracker

This block links two sides, A and B, that each own a small control register holding three general-purpose flag bits. Whatever one side writes into its flags is carried to the other side, where it appears in that side's status word. The transfer is not instant. A write that changes the flag value starts a tracked update request. The request travels to the far side over a modelled delay, and an acknowledge comes back.

While a request is in flight, the writing side sees two pending bits in its own status word. One marks the flag update in progress and the other marks an outstanding event to the far side. During that time any further write to its flags is locked out. Software therefore polls the update-pending bit before it changes the flags again. Software can also use the event-pending bit to confirm that everything sent has landed before it idles the side.

The delay from an accepted write to the far-side update is a parameter `LAT` of at least 1 clock cycle. The two directions run fully independently on a shared clock.

Top module: `flagx_tracker`

## Requirements
- R1: After reset, both control flag readbacks and both 9-bit status words are all zero.
- R2: A write enable with a flag value that differs from the side's current control flags loads that value into the control readback at the next clock edge. At the same edge it sets update-pending (status bit 8) and event-pending (status bit 4) on the writing side.
- R3: The far side's status bits [2:0] take the newly written flag value exactly `LAT` clock edges after the edge that accepted the write, and keep their old value before that.
- R4: Update-pending and event-pending on the writing side both clear at the edge one cycle after the far-side update, `LAT`+1 edges after the accepting edge.
- R5: A write while update-pending is 1 is ignored: the control flags keep their value, no new request starts, and the far side's flags stay unchanged after the running update.
- R6: A write whose flag value equals the current control flags starts no request: update-pending and event-pending stay 0 and nothing changes on the far side.
- R7: The A-to-B and B-to-A directions are independent. Simultaneous or overlapping writes on both sides each complete with their own timing.
- R8: Status bits 3 and 5 to 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_wr_en | input | 1 | Side A control flag write strobe |
| a_wr_flags | input | 3 | Side A flag value to write |
| a_ctrl_flags | output | 3 | Side A control flag readback |
| a_status | output | 9 | Side A status: [2:0] flags from B, [4] event pending, [8] update pending |
| b_wr_en | input | 1 | Side B control flag write strobe |
| b_wr_flags | input | 3 | Side B flag value to write |
| b_ctrl_flags | output | 3 | Side B control flag readback |
| b_status | output | 9 | Side B status: [2:0] flags from A, [4] event pending, [8] update pending |

## Verification
A single write on one side with the other side idle exposes the exact landing cycle of the far flags and the clearing cycle of the pending bits. It separates an off-by-one in the delay from one in the acknowledge path. Back-to-back writes during a flight show whether the lockout holds, and writes of the unchanged value show whether a request is wrongly started. Random writes on both sides at once, with random values and strobe timing, separate the two directions and catch any crosstalk between their request and acknowledge paths.

// File: rtl/flagx_pkg.sv
package flagx_pkg;
    localparam int NFLAG   = 3;
    localparam int STAT_W  = 9;
    localparam int EP_BIT  = 4;
    localparam int FUP_BIT = 8;
    localparam int NSIDE   = 2;

    typedef logic [NFLAG-1:0] flag_t;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_WAIT = 1'b1
    } rx_state_e;
endpackage

// File: rtl/flagx_sender.sv
module flagx_sender
    import flagx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  flag_t wr_flags,
    input  logic  ack_i,
    output flag_t ctrl_o,
    output logic  req_o,
    output logic  fup_o,
    output logic  ep_o
);
    typedef struct packed {
        flag_t ctrl;
        logic  fup;
        logic  ep;
        logic  req;
    } snd_t;

    snd_t q, d;
    logic accept;

    always_comb begin
        d      = q;
        d.req  = 1'b0;
        accept = wr_en && !q.fup && (wr_flags != q.ctrl);
        if (accept) begin
            d.ctrl = wr_flags;
            d.fup  = 1'b1;
            d.ep   = 1'b1;
            d.req  = 1'b1;
        end
        if (ack_i) begin
            d.fup = 1'b0;
            d.ep  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctrl_o = q.ctrl;
    assign req_o  = q.req;
    assign fup_o  = q.fup;
    assign ep_o   = q.ep;

    // R2: a request leaves with both pending bits raised
    p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.req |-> (q.fup && q.ep));
    // R5: flags frozen while an update is in flight
    p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fup && wr_en) |=> $stable(q.ctrl));
    // R4: acknowledge only arrives for an outstanding update
    p_ack_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |-> q.fup);
    // R4: acknowledge drops both pending bits
    p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (!q.fup && !q.ep));
    // R6: rewriting the same value sends nothing
    p_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.fup && wr_en && wr_flags == q.ctrl) |=> !q.req);
endmodule

// File: rtl/flagx_receiver.sv
module flagx_receiver
    import flagx_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req_i,
    input  flag_t pay_i,
    output flag_t far_o,
    output logic  ack_o
);
    localparam int CW = $clog2(LAT + 1);

    typedef struct packed {
        rx_state_e      st;
        logic [CW-1:0]  cnt;
        flag_t          pay;
        flag_t          far;
        logic           ack;
    } rcv_t;

    rcv_t q, d;

    always_comb begin
        d     = q;
        d.ack = 1'b0;
        case (q.st)
            RX_IDLE: begin
                if (req_i) begin
                    d.pay = pay_i;
                    if (LAT == 1) begin
                        d.far = pay_i;
                        d.ack = 1'b1;
                    end else begin
                        d.cnt = CW'(LAT - 1);
                        d.st  = RX_WAIT;
                    end
                end
            end
            RX_WAIT: begin
                if (q.cnt == CW'(1)) begin
                    d.far = q.pay;
                    d.ack = 1'b1;
                    d.st  = RX_IDLE;
                end else begin
                    d.cnt = q.cnt - CW'(1);
                end
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: RX_IDLE, cnt: '0, pay: '0, far: '0, ack: 1'b0};
        else        q <= d;
    end

    assign far_o = q.far;
    assign ack_o = q.ack;

    // R5: sender never issues a second request into a busy receiver
    p_req_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |-> (q.st == RX_IDLE));
    // R4: acknowledge is a single-cycle pulse
    p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.ack |=> !q.ack);
    // R3: far flags only move as the result of a request
    p_far_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RX_IDLE && !req_i) |=> $stable(q.far));
    // R3: at acknowledge the far copy holds the carried value
    p_far_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.ack |-> (q.far == q.pay));
endmodule

// File: rtl/flagx_tracker.sv
module flagx_tracker
    import flagx_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr_en,
    input  logic [NFLAG-1:0]  a_wr_flags,
    output logic [NFLAG-1:0]  a_ctrl_flags,
    output logic [STAT_W-1:0] a_status,
    input  logic              b_wr_en,
    input  logic [NFLAG-1:0]  b_wr_flags,
    output logic [NFLAG-1:0]  b_ctrl_flags,
    output logic [STAT_W-1:0] b_status
);
    logic              wr_en  [NSIDE];
    flag_t             wr_val [NSIDE];
    flag_t             ctrl   [NSIDE];
    logic              req    [NSIDE];
    logic              ack    [NSIDE];
    logic              fup    [NSIDE];
    logic              ep     [NSIDE];
    flag_t             far    [NSIDE];
    logic [STAT_W-1:0] status [NSIDE];

    assign wr_en[0]  = a_wr_en;
    assign wr_en[1]  = b_wr_en;
    assign wr_val[0] = a_wr_flags;
    assign wr_val[1] = b_wr_flags;

    // direction i carries side i's flags to side 1-i
    for (genvar i = 0; i < NSIDE; i++) begin : g_dir
        flagx_sender u_snd (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en[i]),
            .wr_flags (wr_val[i]),
            .ack_i    (ack[i]),
            .ctrl_o   (ctrl[i]),
            .req_o    (req[i]),
            .fup_o    (fup[i]),
            .ep_o     (ep[i])
        );

        flagx_receiver #(.LAT(LAT)) u_rcv (
            .clk   (clk),
            .rst_n (rst_n),
            .req_i (req[i]),
            .pay_i (ctrl[i]),
            .far_o (far[i]),
            .ack_o (ack[i])
        );

        always_comb begin
            status[i]          = '0;
            status[i][NFLAG-1:0] = far[NSIDE-1-i];
            status[i][EP_BIT]  = ep[i];
            status[i][FUP_BIT] = fup[i];
        end
    end

    assign a_ctrl_flags = ctrl[0];
    assign b_ctrl_flags = ctrl[1];
    assign a_status     = status[0];
    assign b_status     = status[1];

    // R8: padding bits of both status words stay zero
    p_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_status[7:5] == 3'b0 && a_status[3] == 1'b0 &&
         b_status[7:5] == 3'b0 && b_status[3] == 1'b0));
    // R7: a far-side flag change on A only follows B's own pending update
    p_indep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(a_status[NFLAG-1:0]) |-> b_status[FUP_BIT]);
endmodule

// File: tb/tb_flagx_tracker.sv
module tb_flagx_tracker;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_wr_en = 1'b0, b_wr_en = 1'b0;
    logic [2:0] a_wr_flags = '0, b_wr_flags = '0;
    logic [2:0] a_ctrl_flags, b_ctrl_flags;
    logic [8:0] a_status, b_status;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state per side: control flags, busy, age, far copy
    int m_ctrl [2];
    int m_busy [2];
    int m_age  [2];
    int m_far  [2];

    always #4 clk = ~clk;

    flagx_tracker #(.LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_wr_en(a_wr_en), .a_wr_flags(a_wr_flags), .a_ctrl_flags(a_ctrl_flags), .a_status(a_status),
        .b_wr_en(b_wr_en), .b_wr_flags(b_wr_flags), .b_ctrl_flags(b_ctrl_flags), .b_status(b_status)
    );

    function automatic int exp_status(int s);
        return (m_busy[s] << 8) | (m_busy[s] << 4) | m_far[1 - s];
    endfunction

    task automatic check(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic model_step(int en0, int v0, int en1, int v1);
        int en [2];
        int v  [2];
        en[0] = en0; v[0] = v0; en[1] = en1; v[1] = v1;
        for (int s = 0; s < 2; s++) begin
            int was_busy;
            was_busy = m_busy[s];
            if (m_busy[s] != 0) begin
                m_age[s]++;
                if (m_age[s] == LAT)     m_far[s]  = m_ctrl[s];
                if (m_age[s] == LAT + 1) m_busy[s] = 0;
            end
            if (was_busy == 0 && en[s] != 0 && v[s] != m_ctrl[s]) begin
                m_ctrl[s] = v[s];
                m_busy[s] = 1;
                m_age[s]  = 0;
            end
        end
    endtask

    task automatic compare_all(string tag);
        check(tag, "a ctrl", int'(a_ctrl_flags), m_ctrl[0]);
        check(tag, "b ctrl", int'(b_ctrl_flags), m_ctrl[1]);
        check(tag, "a status", int'(a_status & 9'h117), exp_status(0));
        check(tag, "b status", int'(b_status & 9'h117), exp_status(1));
        check("R8", "pad bits", int'((a_status | b_status) & 9'h0E8), 0);
    endtask

    // drive at negedge, model after posedge, compare at next negedge
    task automatic cycle(int en0, int v0, int en1, int v1, string tag);
        a_wr_en = en0[0]; a_wr_flags = v0[2:0];
        b_wr_en = en1[0]; b_wr_flags = v1[2:0];
        @(posedge clk);
        model_step(en0, v0, en1, v1);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        for (int s = 0; s < 2; s++) begin
            m_ctrl[s] = 0; m_busy[s] = 0; m_age[s] = 0; m_far[s] = 0;
        end
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");

        // R2 then R3 and R4: single write on A, B idle, watch each cycle
        cycle(1, 5, 0, 0, "R2");
        for (int k = 1; k < LAT; k++) cycle(0, 0, 0, 0, "R3");
        cycle(0, 0, 0, 0, "R3");
        cycle(0, 0, 0, 0, "R4");
        cycle(0, 0, 0, 0, "R4");

        // R5: write, then hammer new values during the flight
        cycle(0, 0, 1, 3, "R2");
        for (int k = 0; k <= LAT; k++) cycle(0, 0, 1, 6, "R5");
        cycle(0, 0, 0, 0, "R5");
        cycle(0, 0, 0, 0, "R5");

        // R6: rewrite unchanged values on both sides
        cycle(1, 5, 1, 3, "R6");
        cycle(1, 5, 1, 3, "R6");
        cycle(0, 0, 0, 0, "R6");

        // R7: simultaneous writes, then staggered
        cycle(1, 2, 1, 7, "R7");
        for (int k = 0; k < LAT + 2; k++) cycle(0, 0, 0, 0, "R7");
        cycle(1, 0, 0, 0, "R7");
        cycle(0, 0, 1, 1, "R7");
        for (int k = 0; k < LAT + 3; k++) cycle(0, 0, 0, 0, "R7");

        // R7: random traffic on both sides
        for (int n = 0; n < 3000; n++) begin
            int e0, e1;
            e0 = ($urandom % 10) < 4 ? 1 : 0;
            e1 = ($urandom % 10) < 4 ? 1 : 0;
            cycle(e0, int'($urandom % 8), e1, int'($urandom % 8), "R7");
        end

        // R1: reset in the middle of a flight
        cycle(1, 4, 1, 2, "R7");
        rst_n = 1'b0;
        for (int s = 0; s < 2; s++) begin
            m_ctrl[s] = 0; m_busy[s] = 0; m_age[s] = 0; m_far[s] = 0;
        end
        #1;
        compare_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        cycle(0, 0, 0, 0, "R1");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule